// File: doc/BRIEF.md
# Serial Synthesizer Control Register File

This block receives configuration words for a frequency synthesizer over a three-wire serial link made of a serial clock, a serial data line and a latch-enable strobe. All three pins are sampled by the block's own system clock through synchronizer stages. Each word is 24 bits long. The four least significant bits name the target register and the upper 20 bits carry its payload. When latch enable rises, the last 24 bits shifted in are committed to the addressed register. The decoded fields then drive the synthesizer's control outputs.

Four registers are decoded:
- Code 0000 holds a 20-bit main-loop divider.
- Code 0001 holds an option word. Its data bit 0 enables automatic power-up.
- Code 0101 holds a 19-bit IF divider and the IF power-down bit.
- Code 0111 holds a 12-bit IF reference divider, a 4-bit main charge-pump gain and a 4-bit access field.

The IF power-down output is not a plain copy of the stored bit. When automatic power-up is enabled, any write to code 0000 clears the stored bit. Independently, a low level on the chip-enable pin forces the loop into power-down. The charge-pump tri-state request follows the effective power-down state.

The serial link has no back-pressure and no handshake. The sender must hold each level for several system clocks, and every word is accepted as it arrives. The control outputs are plain levels and carry no valid/ready pairing.

Top module: `synth_cfg_regfile`

## Requirements
- R1: After reset, every divider, gain, access and option field reads 0, and the IF power-down bit reads 1, so the effective power-down and tri-state outputs are 1.
- R2: Serial data is shifted in MSB first on each rising serial-clock edge. On the rising edge of latch enable, the last 24 bits are committed: bits 3:0 form the address and bits 23:4 form the 20-bit data field. Outputs change only after a commit.
- R3: A word with address 0101 loads the IF divider from data bits 18:0 (word bits 22:4) and the stored IF power-down bit from data bit 19 (word bit 23).
- R4: A word with address 0111 loads the IF reference divider from data bits 11:0, the charge-pump gain from data bits 15:12 and the access field from data bits 19:16.
- R5: A word with address 0000 loads the 20-bit main divider from data bits 19:0.
- R6: A word with address 0001 loads the automatic power-up option from data bit 0.
- R7: A word with address 0000 clears the stored IF power-down bit when the option is 1, and leaves it unchanged when the option is 0.
- R8: While chip enable is low, the effective power-down and tri-state outputs are 1 whatever the stored bit holds. While chip enable is high, both outputs equal the stored bit.
- R9: A word with any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is captured on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch enable; its rising edge commits the word |
| chip_en | input | 1 | Chip enable; a low level forces IF power-down |
| main_div | output | 20 | Main-loop divider value |
| if_div | output | 19 | IF divider value |
| if_ref_div | output | 12 | IF reference divider value |
| cp_gain | output | 4 | Main charge-pump gain |
| access_code | output | 4 | Access field |
| auto_pwrup | output | 1 | Automatic power-up option |
| if_pwrdn | output | 1 | Effective IF power-down |
| cp_tristate | output | 1 | Charge-pump tri-state request |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, a 4-bit address and a 20-bit payload split 19/1 and 12/4/4. The serial pins are held for four system clocks per level. With these widths, all-ones and single-bit divider values and the top data bit reach the field edges. The auto power-up path is exercised with the option both clear and set, and chip enable is toggled against both stored power-down values.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADR_MAIN = 4'b0000;
  localparam logic [ADDR_W-1:0] ADR_OPT  = 4'b0001;
  localparam logic [ADDR_W-1:0] ADR_IFN  = 4'b0101;
  localparam logic [ADDR_W-1:0] ADR_IFR  = 4'b0111;

  function automatic logic addr_known(input logic [ADDR_W-1:0] a);
    return (a == ADR_MAIN) || (a == ADR_OPT) || (a == ADR_IFN) || (a == ADR_IFR);
  endfunction
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              le_s,
  output logic [WORD_W-1:0] word,
  output logic              commit
);
  logic              sclk_q, le_q;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
      shreg  <= '0;
      word   <= '0;
      commit <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      le_q   <= le_s;
      commit <= 1'b0;
      if (sclk_s && !sclk_q) shreg <= {shreg[WORD_W-2:0], sdat_s};
      if (le_s && !le_q) begin
        word   <= shreg;
        commit <= 1'b1;
      end
    end
  end

  // R2: a latch strobe yields a single-cycle commit pulse
  assert_commit_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R2: the committed word only moves together with a commit
  assert_word_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(word) || commit);
endmodule

// File: rtl/scfg_regbank.sv
module scfg_regbank
  import scfg_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int N_W    = 19,
  parameter int R_W    = 12,
  parameter int CPG_W  = 4,
  parameter int ACC_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [ADDR_W+DATA_W-1:0] word,
  output logic [DATA_W-1:0]        main_div,
  output logic [N_W-1:0]           if_div,
  output logic                     if_pd,
  output logic [R_W-1:0]           if_ref_div,
  output logic [CPG_W-1:0]         cp_gain,
  output logic [ACC_W-1:0]         access_code,
  output logic                     auto_pwrup
);
  localparam int CPG_LO = R_W;
  localparam int ACC_LO = R_W + CPG_W;

  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;

  assign addr = word[ADDR_W-1:0];
  assign data = word[ADDR_W+DATA_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_div    <= '0;
      if_div      <= '0;
      if_pd       <= 1'b1;
      if_ref_div  <= '0;
      cp_gain     <= '0;
      access_code <= '0;
      auto_pwrup  <= 1'b0;
    end else if (commit) begin
      case (addr)
        ADR_MAIN: begin
          main_div <= data;
          if (auto_pwrup) if_pd <= 1'b0;
        end
        ADR_OPT: auto_pwrup <= data[0];
        ADR_IFN: begin
          if_div <= data[N_W-1:0];
          if_pd  <= data[DATA_W-1];
        end
        ADR_IFR: begin
          if_ref_div  <= data[R_W-1:0];
          cp_gain     <= data[CPG_LO+CPG_W-1:CPG_LO];
          access_code <= data[ACC_LO+ACC_W-1:ACC_LO];
        end
        default: ;
      endcase
    end
  end

  // R9: unknown addresses leave every register alone
  assert_unknown_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !addr_known(addr)) |=> ($stable(main_div) && $stable(if_div) && $stable(if_pd)
      && $stable(if_ref_div) && $stable(cp_gain) && $stable(access_code) && $stable(auto_pwrup)));
  // R2: no register moves without a commit
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(main_div) && $stable(if_pd) && $stable(auto_pwrup)));
  // R7: main write with option set powers the IF loop up
  assert_auto_pwrup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == ADR_MAIN && auto_pwrup) |=> !if_pd);
  // R7: main write with option clear keeps the stored bit
  assert_no_auto_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == ADR_MAIN && !auto_pwrup) |=> $stable(if_pd));
endmodule

// File: rtl/synth_cfg_regfile.sv
module synth_cfg_regfile
  import scfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 20,
  parameter int N_W         = 19,
  parameter int R_W         = 12,
  parameter int CPG_W       = 4,
  parameter int ACC_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  input  logic              chip_en,
  output logic [DATA_W-1:0] main_div,
  output logic [N_W-1:0]    if_div,
  output logic [R_W-1:0]    if_ref_div,
  output logic [CPG_W-1:0]  cp_gain,
  output logic [ACC_W-1:0]  access_code,
  output logic              auto_pwrup,
  output logic              if_pwrdn,
  output logic              cp_tristate
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int N_PINS = 3;

  logic [N_PINS-1:0] pins_raw, pins_s;
  logic [WORD_W-1:0] word;
  logic              commit, if_pd_q;

  assign pins_raw = {ser_le, ser_dat, ser_clk};

  for (genvar i = 0; i < N_PINS; i++) begin : g_sync
    scfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pins_raw[i]), .q(pins_s[i]));
  end

  scfg_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(pins_s[0]), .sdat_s(pins_s[1]),
    .le_s(pins_s[2]), .word(word), .commit(commit));

  scfg_regbank #(.DATA_W(DATA_W), .N_W(N_W), .R_W(R_W), .CPG_W(CPG_W), .ACC_W(ACC_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit), .word(word),
    .main_div(main_div), .if_div(if_div), .if_pd(if_pd_q), .if_ref_div(if_ref_div),
    .cp_gain(cp_gain), .access_code(access_code), .auto_pwrup(auto_pwrup));

  assign if_pwrdn    = if_pd_q | ~chip_en;
  assign cp_tristate = if_pwrdn;

  // R8: chip enable low always yields power-down at the outputs
  assert_ce_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (if_pwrdn && cp_tristate));
  // R3: a stored power-down of 1 is visible whatever chip enable does
  assert_pd_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    if_pd_q |-> if_pwrdn);
endmodule

// File: tb/synth_cfg_regfile_tb_top.sv
module synth_cfg_regfile_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0, chip_en = 1'b1;
  logic [19:0] main_div;
  logic [18:0] if_div;
  logic [11:0] if_ref_div;
  logic [3:0]  cp_gain, access_code;
  logic        auto_pwrup, if_pwrdn, cp_tristate;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  synth_cfg_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .chip_en(chip_en), .main_div(main_div), .if_div(if_div), .if_ref_div(if_ref_div),
    .cp_gain(cp_gain), .access_code(access_code), .auto_pwrup(auto_pwrup),
    .if_pwrdn(if_pwrdn), .cp_tristate(cp_tristate));

  localparam int NV = 8;
  // word, then expected main_div, if_div, pd, ref, gain, access, option
  localparam logic [23:0] V_WORD [NV] = '{24'h123455, 24'hA35C17, 24'hFEDCB0, 24'hFFFFF5,
                                          24'h000011, 24'h000010, 24'hABCDEF, 24'h800185};
  localparam logic [19:0] V_MAIN [NV] = '{20'h0, 20'h0, 20'hFEDCB, 20'hFEDCB,
                                          20'hFEDCB, 20'h1, 20'h1, 20'h1};
  localparam logic [18:0] V_IFN  [NV] = '{19'h12345, 19'h12345, 19'h12345, 19'h7FFFF,
                                          19'h7FFFF, 19'h7FFFF, 19'h7FFFF, 19'h18};
  localparam logic        V_PD   [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [11:0] V_REF  [NV] = '{12'h0, 12'h5C1, 12'h5C1, 12'h5C1,
                                          12'h5C1, 12'h5C1, 12'h5C1, 12'h5C1};
  localparam logic [3:0]  V_GAIN [NV] = '{4'h0, 4'h3, 4'h3, 4'h3, 4'h3, 4'h3, 4'h3, 4'h3};
  localparam logic [3:0]  V_ACC  [NV] = '{4'h0, 4'hA, 4'hA, 4'hA, 4'hA, 4'hA, 4'hA, 4'hA};
  localparam logic        V_OPT  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] w);
    for (int b = 23; b >= 0; b--) begin
      ser_dat = w[b];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(4);
    ser_le = 1'b1;
    wait_clk(4);
    ser_le = 1'b0;
    wait_clk(8);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R1 reset state
    check("R1 main_div", 32'(main_div), 0);
    check("R1 if_div", 32'(if_div), 0);
    check("R1 ref", 32'(if_ref_div), 0);
    check("R1 gain", 32'(cp_gain), 0);
    check("R1 access", 32'(access_code), 0);
    check("R1 option", 32'(auto_pwrup), 0);
    check("R1 pwrdn", 32'(if_pwrdn), 1);
    check("R1 tristate", 32'(cp_tristate), 1);

    // vector walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      send(V_WORD[i]);
      check("R5 main_div", 32'(main_div), 32'(V_MAIN[i]));
      check("R3 if_div", 32'(if_div), 32'(V_IFN[i]));
      check("R7 pwrdn", 32'(if_pwrdn), 32'(V_PD[i]));
      check("R4 ref", 32'(if_ref_div), 32'(V_REF[i]));
      check("R4 gain", 32'(cp_gain), 32'(V_GAIN[i]));
      check("R4 access", 32'(access_code), 32'(V_ACC[i]));
      check("R6 option", 32'(auto_pwrup), 32'(V_OPT[i]));
      check("R2 tristate", 32'(cp_tristate), 32'(V_PD[i]));
    end

    // R9: unknown address 0011 with full data leaves all registers
    send(24'hFFFFF3);
    check("R9 main_div", 32'(main_div), 32'h1);
    check("R9 option", 32'(auto_pwrup), 1);
    check("R9 pwrdn", 32'(if_pwrdn), 1);

    // R7: option clear, stored power-down survives a main write
    send(24'h000001);
    check("R6 option cleared", 32'(auto_pwrup), 0);
    send(24'h000050);
    check("R7 no auto", 32'(if_pwrdn), 1);
    check("R5 main_div 5", 32'(main_div), 32'h5);

    // R8: chip enable override against both stored values
    send(24'h000185);
    check("R8 stored 0 ce high", 32'(if_pwrdn), 0);
    chip_en = 1'b0;
    wait_clk(1);
    check("R8 ce low pwrdn", 32'(if_pwrdn), 1);
    check("R8 ce low tristate", 32'(cp_tristate), 1);
    check("R8 ce low if_div kept", 32'(if_div), 32'h18);
    chip_en = 1'b1;
    wait_clk(1);
    check("R8 ce high again", 32'(if_pwrdn), 0);

    // R2: serial activity without a latch strobe changes nothing
    for (int b = 0; b < 8; b++) begin
      ser_dat = 1'b1; wait_clk(4); ser_clk = 1'b1; wait_clk(4); ser_clk = 1'b0;
    end
    wait_clk(8);
    check("R2 no strobe", 32'(if_div), 32'h18);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule